// File: doc/BRIEF.md
# Codec Register Access Bridge with GPIO Shadow

This block sits between a processor register bus and the frame-level side of a serial codec link. The processor sees each 16-bit codec register on its own 32-bit word. The bridge turns a host byte address into a codec register address and loads a write or read command into the next outgoing frame. For a read, it returns the data that comes back in the status slots of a later incoming frame. Only one command is in flight at a time, and the host bus stalls until that command completes.

The modem GPIO register at codec address 0x54 is handled differently. Every incoming frame carries the current GPIO pin state, and the bridge keeps a local copy of it. A host read of that register is answered at once from the copy and never reaches the link. A host write to it goes out over the link like any other write. If a read gets no matching status within a set number of received frames, it completes with an error flag and all-ones data.

Top module: `codec_reg_bridge`

## Requirements
- R1: The codec register address sent on the link is (req_addr >> 2) * 2. Host address bits [1:0] are ignored, so host byte address 0xA8 maps to codec address 0x54.
- R2: A host write to any register, including 0x54, raises a link command with the read flag at 0 and the host write data. The host sees req_ready for exactly one cycle, in the cycle where tx_cmd_taken is high. rsp_err is 0 on a write.
- R3: A host read of any register other than 0x54 raises a link command with the read flag at 1 and data 0x0000, whatever is on req_wdata.
- R4: Only one command is outstanding at a time. tx_cmd_valid rises in the cycle after the request is seen, and its fields stay stable until tx_cmd_taken. req_ready stays low while the command is pending.
- R5: Once a read command is taken, the read completes in the cycle of the first received frame whose status slot is flagged valid and whose status address equals the command address. rsp_rdata is the status data and rsp_err is 0. The bridge ignores non-matching status, status flagged invalid, and status that arrives before the command is taken.
- R6: A host read of address 0x54 completes with req_ready in the same cycle it is presented while the bridge is idle. No link command is produced.
- R7: The shadow loads rx_gpio_data on every cycle with rx_frame_valid, whether or not a command is pending. A shadow read in that same cycle returns the previous value. The new value is returned from the next cycle on.
- R8: If TIMEOUT_FRAMES received frames pass after a read is taken without a match, the read completes on the last of those frames with rsp_err=1 and rsp_rdata=0xFFFF.
- R9: A matching status that arrives in the frame that would expire the timeout completes the read normally, with its data and rsp_err=0.
- R10: After reset, tx_cmd_valid and req_ready are low and the shadow holds SHADOW_RESET.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present, held until req_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Host byte address |
| req_wdata | input | 16 | Host write data |
| req_ready | output | 1 | Request completes this cycle |
| rsp_rdata | output | 16 | Read data, valid with req_ready on a read |
| rsp_err | output | 1 | Read timed out |
| tx_cmd_valid | output | 1 | Command pending for the outgoing frame |
| tx_cmd_read | output | 1 | Command is a read |
| tx_cmd_addr | output | 7 | Codec register address |
| tx_cmd_data | output | 16 | Command data slot |
| tx_cmd_taken | input | 1 | Serializer loaded the command into a frame |
| rx_frame_valid | input | 1 | One received frame, one cycle |
| rx_status_valid | input | 1 | Status slots of this frame are valid |
| rx_status_addr | input | 7 | Returned status address |
| rx_status_data | input | 16 | Returned status data |
| rx_gpio_data | input | 16 | GPIO pin state carried by this frame |

## Verification
Two pairs of events can land in the same cycle. The first pair is a shadow read and a received frame that reloads the shadow. The bench presents a 0x54 read in exactly the cycle that carries a new GPIO value. It expects the old value, then expects the new value on the next read. The second pair is a matching status and timeout expiry. The bench holds back the matching status until the frame that would exhaust the timeout, and expects real data with no error flag. A behavioural model checks every output on every clock.

// File: rtl/crb_pkg.sv
package crb_pkg;

    localparam int HOST_AW  = 8;
    localparam int CODEC_AW = 7;
    localparam int DATA_W   = 16;

    localparam logic [CODEC_AW-1:0] GPIO_CODEC_ADDR = 7'h54;
    localparam logic [DATA_W-1:0]   TIMEOUT_DATA    = {DATA_W{1'b1}};

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } ctl_state_e;

    typedef struct packed {
        logic                is_read;
        logic [CODEC_AW-1:0] addr;
        logic [DATA_W-1:0]   data;
    } link_cmd_t;

    // Word-aligned host byte address -> 16-bit codec register address.
    function automatic logic [CODEC_AW-1:0] host_to_codec(input logic [HOST_AW-1:0] a);
        return CODEC_AW'((a >> 2) << 1);
    endfunction

    function automatic logic is_shadowed(input logic [CODEC_AW-1:0] caddr);
        return caddr == GPIO_CODEC_ADDR;
    endfunction

endpackage

// File: rtl/crb_gpio_shadow.sv
module crb_gpio_shadow
    import crb_pkg::*;
#(
    parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_valid,
    input  logic [DATA_W-1:0] gpio_in,
    output logic [DATA_W-1:0] shadow_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= RESET_VAL;
        end else if (frame_valid) begin
            shadow_q <= gpio_in;
        end
    end

    AST_SHADOW_TRACKS: assert property (@(posedge clk) disable iff (rst)
        frame_valid |=> shadow_q == $past(gpio_in)); // R7

endmodule

// File: rtl/crb_frame_timer.sv
module crb_frame_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic frame_tick,
    output logic expire
);

    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (frame_tick && !expire) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = run && frame_tick && (cnt == CNT_W'(LIMIT - 1));

    AST_TIMER_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) < LIMIT); // R8

endmodule

// File: rtl/crb_ctrl.sv
module crb_ctrl
    import crb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [HOST_AW-1:0]  req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                req_ready,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                rsp_err,
    input  logic [DATA_W-1:0]   shadow,
    output logic                tx_valid,
    output link_cmd_t           tx_cmd,
    input  logic                tx_taken,
    input  logic                rx_frame_valid,
    input  logic                rx_status_valid,
    input  logic [CODEC_AW-1:0] rx_status_addr,
    input  logic [DATA_W-1:0]   rx_status_data,
    output logic                timer_run,
    input  logic                timer_expire
);

    ctl_state_e          state, state_n;
    link_cmd_t           cmd_q;
    logic [CODEC_AW-1:0] req_caddr;
    logic                local_read;
    logic                status_hit;

    assign req_caddr  = host_to_codec(req_addr);
    assign local_read = req_valid && !req_write && is_shadowed(req_caddr);
    assign status_hit = (state == ST_WAIT) && rx_frame_valid && rx_status_valid
                        && (rx_status_addr == cmd_q.addr);

    always_comb begin
        state_n   = state;
        req_ready = 1'b0;
        rsp_rdata = '0;
        rsp_err   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (local_read) begin
                    req_ready = 1'b1;
                    rsp_rdata = shadow;
                end else if (req_valid) begin
                    state_n = ST_SEND;
                end
            end
            ST_SEND: begin
                if (tx_taken) begin
                    if (cmd_q.is_read) begin
                        state_n = ST_WAIT;
                    end else begin
                        req_ready = 1'b1;
                        state_n   = ST_IDLE;
                    end
                end
            end
            ST_WAIT: begin
                if (status_hit) begin
                    req_ready = 1'b1;
                    rsp_rdata = rx_status_data;
                    state_n   = ST_IDLE;
                end else if (timer_expire) begin
                    req_ready = 1'b1;
                    rsp_rdata = TIMEOUT_DATA;
                    rsp_err   = 1'b1;
                    state_n   = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cmd_q <= '0;
        end else begin
            state <= state_n;
            if (state == ST_IDLE && req_valid && !local_read) begin
                cmd_q.is_read <= !req_write;
                cmd_q.addr    <= req_caddr;
                cmd_q.data    <= req_write ? req_wdata : '0;
            end
        end
    end

    assign tx_valid  = (state == ST_SEND);
    assign tx_cmd    = cmd_q;
    assign timer_run = (state == ST_WAIT);

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_taken |=> tx_valid && $stable(tx_cmd)); // R4

    AST_NO_READY_PENDING: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_taken |-> !req_ready); // R4

    AST_GPIO_LOCAL: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) && local_read |=> !tx_valid); // R6

    AST_READ_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        tx_valid && tx_cmd.is_read |-> tx_cmd.data == '0); // R3

    AST_WRITE_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        req_ready && req_write |-> !rsp_err); // R2

endmodule

// File: rtl/codec_reg_bridge.sv
module codec_reg_bridge
    import crb_pkg::*;
#(
    parameter int                TIMEOUT_FRAMES = 8,
    parameter logic [DATA_W-1:0] SHADOW_RESET   = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [HOST_AW-1:0]  req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                req_ready,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                rsp_err,
    output logic                tx_cmd_valid,
    output logic                tx_cmd_read,
    output logic [CODEC_AW-1:0] tx_cmd_addr,
    output logic [DATA_W-1:0]   tx_cmd_data,
    input  logic                tx_cmd_taken,
    input  logic                rx_frame_valid,
    input  logic                rx_status_valid,
    input  logic [CODEC_AW-1:0] rx_status_addr,
    input  logic [DATA_W-1:0]   rx_status_data,
    input  logic [DATA_W-1:0]   rx_gpio_data
);

    logic [DATA_W-1:0] shadow;
    link_cmd_t         cmd;
    logic              timer_run;
    logic              timer_expire;

    crb_gpio_shadow #(.RESET_VAL(SHADOW_RESET)) u_shadow (
        .clk         (clk),
        .rst         (rst),
        .frame_valid (rx_frame_valid),
        .gpio_in     (rx_gpio_data),
        .shadow_q    (shadow)
    );

    crb_frame_timer #(.LIMIT(TIMEOUT_FRAMES)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .run        (timer_run),
        .frame_tick (rx_frame_valid),
        .expire     (timer_expire)
    );

    crb_ctrl u_ctrl (
        .clk             (clk),
        .rst             (rst),
        .req_valid       (req_valid),
        .req_write       (req_write),
        .req_addr        (req_addr),
        .req_wdata       (req_wdata),
        .req_ready       (req_ready),
        .rsp_rdata       (rsp_rdata),
        .rsp_err         (rsp_err),
        .shadow          (shadow),
        .tx_valid        (tx_cmd_valid),
        .tx_cmd          (cmd),
        .tx_taken        (tx_cmd_taken),
        .rx_frame_valid  (rx_frame_valid),
        .rx_status_valid (rx_status_valid),
        .rx_status_addr  (rx_status_addr),
        .rx_status_data  (rx_status_data),
        .timer_run       (timer_run),
        .timer_expire    (timer_expire)
    );

    assign tx_cmd_read = cmd.is_read;
    assign tx_cmd_addr = cmd.addr;
    assign tx_cmd_data = cmd.data;

endmodule

// File: tb/test_codec_reg_bridge.sv
`timescale 1ns/1ps
module test_codec_reg_bridge;

    localparam int T = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [7:0]  req_addr;
    logic [15:0] req_wdata;
    logic        req_ready;
    logic [15:0] rsp_rdata;
    logic        rsp_err;
    logic        tx_cmd_valid, tx_cmd_read;
    logic [6:0]  tx_cmd_addr;
    logic [15:0] tx_cmd_data;
    logic        tx_cmd_taken;
    logic        rx_frame_valid, rx_status_valid;
    logic [6:0]  rx_status_addr;
    logic [15:0] rx_status_data, rx_gpio_data;

    always #2.5 clk = ~clk;

    codec_reg_bridge #(.TIMEOUT_FRAMES(T), .SHADOW_RESET(16'h0000)) i_codec_reg_bridge (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .tx_cmd_valid(tx_cmd_valid), .tx_cmd_read(tx_cmd_read),
        .tx_cmd_addr(tx_cmd_addr), .tx_cmd_data(tx_cmd_data), .tx_cmd_taken(tx_cmd_taken),
        .rx_frame_valid(rx_frame_valid), .rx_status_valid(rx_status_valid),
        .rx_status_addr(rx_status_addr), .rx_status_data(rx_status_data),
        .rx_gpio_data(rx_gpio_data)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R10";

    // behavioural reference state: 0 idle, 1 command pending, 2 awaiting status
    int m_phase  = 0;
    bit m_rd     = 0;
    int m_addr   = 0;
    int m_data   = 0;
    int m_waited = 0;
    int m_shadow = 0;

    task automatic chk(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        bit e_ready = 0;
        int e_rdata = 0;
        bit e_err   = 0;
        bit e_txv;
        int caddr;
        int n_phase;
        #2;
        caddr   = (int'(req_addr) >> 2) * 2;
        e_txv   = (m_phase == 1);
        n_phase = m_phase;
        case (m_phase)
            0: if (req_valid) begin
                if (!req_write && caddr == 'h54) begin
                    e_ready = 1; e_rdata = m_shadow;
                end else begin
                    n_phase = 1; m_rd = !req_write; m_addr = caddr;
                    m_data = req_write ? int'(req_wdata) : 0;
                end
            end
            1: if (tx_cmd_taken) begin
                if (m_rd) begin n_phase = 2; m_waited = 0; end
                else begin e_ready = 1; n_phase = 0; end
            end
            default: if (rx_frame_valid) begin
                if (rx_status_valid && int'(rx_status_addr) == m_addr) begin
                    e_ready = 1; e_rdata = int'(rx_status_data); n_phase = 0;
                end else if (m_waited + 1 == T) begin
                    e_ready = 1; e_err = 1; e_rdata = 'hFFFF; n_phase = 0;
                end else begin
                    m_waited++;
                end
            end
        endcase
        chk("req_ready", int'(req_ready), int'(e_ready));
        chk("tx_cmd_valid", int'(tx_cmd_valid), int'(e_txv));
        if (e_txv) begin
            chk("tx_cmd_read", int'(tx_cmd_read), int'(m_rd));
            chk("tx_cmd_addr", int'(tx_cmd_addr), m_addr);
            chk("tx_cmd_data", int'(tx_cmd_data), m_data);
        end
        if (e_ready && !req_write) begin
            chk("rsp_rdata", int'(rsp_rdata), e_rdata);
            chk("rsp_err", int'(rsp_err), int'(e_err));
        end
        if (e_ready && req_write) chk("rsp_err", int'(rsp_err), 0);
        if (rx_frame_valid) m_shadow = int'(rx_gpio_data);
        m_phase = n_phase;
        @(posedge clk);
        #1;
        if (e_ready) req_valid = 1'b0;
    endtask

    task automatic req(bit w, logic [7:0] a, logic [15:0] d);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    endtask

    task automatic frame(bit sv, logic [6:0] sa, logic [15:0] sd, logic [15:0] g);
        rx_frame_valid = 1'b1; rx_status_valid = sv;
        rx_status_addr = sa; rx_status_data = sd; rx_gpio_data = g;
        tick();
        rx_frame_valid = 1'b0; rx_status_valid = 1'b0;
    endtask

    task automatic take();
        tx_cmd_taken = 1'b1;
        tick();
        tx_cmd_taken = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R4 watchdog: actual hang expected completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1;
        req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
        tx_cmd_taken = 0; rx_frame_valid = 0; rx_status_valid = 0;
        rx_status_addr = 0; rx_status_data = 0; rx_gpio_data = 0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        tag = "R10 reset";
        chk("req_ready", int'(req_ready), 0);
        chk("tx_cmd_valid", int'(tx_cmd_valid), 0);
        req(0, 8'hA8, 16'h0); tick();               // shadow reset value

        tag = "R1 R2 R4 write held until taken";
        req(1, 8'h17, 16'hC0DE); tick(); tick(); tick();
        take(); tick();

        tag = "R2 R1 write to gpio address";
        req(1, 8'hA8, 16'h00F0); tick(); take(); tick();

        tag = "R7 shadow load";
        frame(0, 7'h0, 16'h0, 16'hBEEF);
        req(0, 8'hA8, 16'h0); tick();

        tag = "R7 R6 same-cycle shadow read";
        req(0, 8'hAB, 16'h0); frame(0, 7'h0, 16'h0, 16'h1234);
        req(0, 8'hA8, 16'h0); tick();

        tag = "R3 R5 read match";
        req(0, 8'h40, 16'hFFFF); tick(); tick(); take();
        frame(1, 7'h22, 16'h1111, 16'h2222);
        frame(0, 7'h20, 16'h3333, 16'h2222);
        tick();
        frame(1, 7'h20, 16'hA5A5, 16'h4444);

        tag = "R6 R7 shadow refreshed during wait";
        req(0, 8'hA8, 16'h0); tick();

        tag = "R8 timeout";
        req(0, 8'h0C, 16'h0); tick(); take();
        frame(1, 7'h02, 16'h1, 16'h4444);
        frame(0, 7'h06, 16'h2, 16'h4444);
        tick();
        frame(1, 7'h08, 16'h3, 16'h4444);
        frame(1, 7'h0A, 16'h4, 16'h4444);

        tag = "R9 match at expiry frame";
        req(0, 8'h1C, 16'h0); tick(); take();
        for (int i = 0; i < T - 1; i++) frame(1, 7'h0C, 16'h5, 16'h4444);
        frame(1, 7'h0E, 16'h7E57, 16'h4444);

        tag = "R5 status before take ignored";
        frame(1, 7'h0E, 16'h9999, 16'h5555);
        req(0, 8'h1C, 16'h0); frame(1, 7'h0E, 16'h9999, 16'h5555);
        tick(); take(); tick();
        frame(1, 7'h0E, 16'h0042, 16'h5555);

        tag = "R6 final shadow read";
        req(0, 8'hA9, 16'h0); tick(); tick();

        summary();
        $finish;
    end

endmodule